// File: doc/BRIEF.md
# Host-to-DSP Mailbox Bus Bridge

This block lets a host CPU on an asynchronous system bus reach a coprocessor card whose registers exist only in the memory of a local DSP. The bridge decodes no host registers itself. It synchronises the host address, direction, write data and address-valid strobe into the DSP clock. It compares the upper address bits against a fixed card identity. On a match it latches the access and raises an interrupt to the DSP.

DSP firmware reads a mailbox port to learn which pseudo register the host addressed, and that read withdraws the interrupt. The DSP then moves data through a single inbound register, which holds the host write data, or a single outbound register, which drives the host read data. It ends the host cycle by reading the inbound port. That read is a real read for host writes and a dummy read for host reads, and it pulls the active-low data acknowledge. The acknowledge is held until the host drops or changes its address.

A separate set/reset request flop lets the DSP interrupt the host. The system reset and a DSP clear command both reset it, and a reset beats a set.

Top module: `hdmb_bridge`

## Requirements
- R1: After reset, host_dack_n and host_irq_n are 1 and dsp_irq is 0.
- R2: When host_avalid is 1 and host_addr[HOST_AW-1:REG_W] equals CARD_ID, dsp_irq goes to 1 within SYNC_STAGES+1 clock cycles.
- R3: While dsp_irq is 1, a DSP read of port P_ADDR returns {host_rnw, host_addr[REG_W-1:0]} of the latched access, zero-extended. host_rnw=1 means a host read, and it sits at bit REG_W. dsp_irq is 0 from the next cycle on.
- R4: A DSP read of port P_DIN returns the host write data captured when a host write access was latched.
- R5: A DSP write to port P_DOUT drives dsp_wdata onto host_rdata from the next cycle.
- R6: A DSP read of P_DIN after the mailbox read drives host_dack_n to 0 on the next cycle, for host writes and host reads alike. A P_DIN read while dsp_irq is still 1 leaves host_dack_n at 1.
- R7: host_dack_n stays 0 while the host keeps the same card address valid. It returns to 1 within SYNC_STAGES+1 cycles after the host drops host_avalid or changes the register address.
- R8: While an access is pending, a new host address does not replace the latched one, and no acknowledge is given. After the first access completes, the new address starts its own access.
- R9: A DSP write to port P_HIRQ with dsp_wdata[0]=1 drives host_irq_n to 0 on the next cycle. Writing dsp_wdata[1]=1 drives it to 1. With both bits set, the clear wins.
- R10: Asserting rst_n low clears a pending host interrupt request at once.
- R11: An address outside the card identity, or any address with host_avalid at 0, raises no DSP interrupt and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DSP clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| host_avalid | input | 1 | Host address-valid strobe, asynchronous |
| host_rnw | input | 1 | Host direction, 1 = read |
| host_addr | input | HOST_AW | Host address bus |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Outbound data register to the host |
| host_dack_n | output | 1 | Data acknowledge to the host, active low |
| host_irq_n | output | 1 | Interrupt request to the host, active low |
| dsp_addr | input | LOC_AW | DSP local port address |
| dsp_rd | input | 1 | DSP port read strobe |
| dsp_wr | input | 1 | DSP port write strobe |
| dsp_wdata | input | DATA_W | DSP write data |
| dsp_rdata | output | DATA_W | DSP read data (port mux) |
| dsp_irq | output | 1 | Interrupt to the DSP, active high |

## Verification
The bound checker watches every cycle for the cycle-level rules. These are: a match from idle raises the DSP interrupt, the mailbox read drops it, and the latched address holds while the interrupt stands. They also cover the inbound read in the transfer phase that acknowledges, the acknowledge never overlapping the interrupt, outbound writes reaching the host, and the set/clear priority of the host request. Only the bench scenarios can show the end-to-end ordering through the synchronisers. That includes host writes and reads completing, acknowledge release on address removal or change, and a second access stalling behind the first. It also includes rejection of foreign addresses and the asynchronous reset of the host request.

// File: rtl/hdmb_pkg.sv
package hdmb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PEND = 2'd1,
      ST_XFER = 2'd2,
      ST_ACK  = 2'd3
   } hdmb_state_t;
endpackage

// File: rtl/hdmb_sync.sv
module hdmb_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hdmb_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hdmb_id_match.sv
module hdmb_id_match #(
   parameter int HOST_AW = 16,
   parameter int REG_W   = 4,
   parameter logic [HOST_AW-REG_W-1:0] CARD_ID = '0
) (
   input  logic               avalid,
   input  logic [HOST_AW-1:0] addr,
   output logic               sel,
   output logic [REG_W-1:0]   reg_idx
);
   localparam int ID_W = HOST_AW - REG_W;

   if (REG_W < 1 || ID_W < 1) begin : g_bad_split
      $error("hdmb_id_match: address split leaves an empty field");
   end

   assign sel     = avalid && (addr[HOST_AW-1:REG_W] == CARD_ID);
   assign reg_idx = addr[REG_W-1:0];
endmodule

// File: rtl/hdmb_xfer_ctl.sv
module hdmb_xfer_ctl
   import hdmb_pkg::*;
#(
   parameter int REG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rnw,
   input  logic [REG_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_mbox,
   input  logic              rd_din,
   output hdmb_state_t       st,
   output logic [REG_W:0]    lat,
   output logic [DATA_W-1:0] din
);
   hdmb_state_t st_q;
   logic [REG_W:0]    lat_q;
   logic [DATA_W-1:0] din_q;
   logic              done;

   assign done = !sel || (reg_idx != lat_q[REG_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         lat_q <= '0;
         din_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (sel) begin
               st_q  <= ST_PEND;
               lat_q <= {rnw, reg_idx};
               if (!rnw) din_q <= wdata;
            end
            ST_PEND: if (rd_mbox) st_q <= ST_XFER;
            ST_XFER: if (rd_din)  st_q <= ST_ACK;
            ST_ACK:  if (done)    st_q <= ST_IDLE;
            default:              st_q <= ST_IDLE;
         endcase
      end
   end

   assign st  = st_q;
   assign lat = lat_q;
   assign din = din_q;
endmodule

// File: rtl/hdmb_req_ff.sv
module hdmb_req_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       q <= 1'b0;
      else if (clr_req) q <= 1'b0;
      else if (set_req) q <= 1'b1;
endmodule

// File: rtl/hdmb_bridge.sv
module hdmb_bridge
   import hdmb_pkg::*;
#(
   parameter int HOST_AW     = 16,
   parameter int REG_W       = 4,
   parameter int DATA_W      = 16,
   parameter logic [HOST_AW-REG_W-1:0] CARD_ID = 12'hA5C,
   parameter int LOC_AW      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int P_ADDR      = 0,
   parameter int P_DIN       = 1,
   parameter int P_DOUT      = 2,
   parameter int P_HIRQ      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_avalid,
   input  logic              host_rnw,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_dack_n,
   output logic              host_irq_n,
   input  logic [LOC_AW-1:0] dsp_addr,
   input  logic              dsp_rd,
   input  logic              dsp_wr,
   input  logic [DATA_W-1:0] dsp_wdata,
   output logic [DATA_W-1:0] dsp_rdata,
   output logic              dsp_irq
);
   localparam int SYNC_W = 2 + HOST_AW + DATA_W;
   localparam int PORTS  = 1 << LOC_AW;
   localparam logic [LOC_AW-1:0] A_ADDR = LOC_AW'(P_ADDR);
   localparam logic [LOC_AW-1:0] A_DIN  = LOC_AW'(P_DIN);
   localparam logic [LOC_AW-1:0] A_DOUT = LOC_AW'(P_DOUT);
   localparam logic [LOC_AW-1:0] A_HIRQ = LOC_AW'(P_HIRQ);

   if (DATA_W < REG_W + 1 || DATA_W < 2) begin : g_bad_data
      $error("hdmb_bridge: DATA_W too narrow for the mailbox word");
   end
   if (P_ADDR >= PORTS || P_DIN >= PORTS || P_DOUT >= PORTS || P_HIRQ >= PORTS) begin : g_bad_port
      $error("hdmb_bridge: port address exceeds LOC_AW");
   end
   if (P_ADDR == P_DIN || P_ADDR == P_DOUT || P_ADDR == P_HIRQ ||
       P_DIN == P_DOUT || P_DIN == P_HIRQ || P_DOUT == P_HIRQ) begin : g_bad_map
      $error("hdmb_bridge: port addresses must differ");
   end

   // host side brought into the DSP clock domain
   logic [SYNC_W-1:0]  sync_q;
   logic               avalid_s, rnw_s;
   logic [HOST_AW-1:0] addr_s;
   logic [DATA_W-1:0]  wdata_s;

   hdmb_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({host_avalid, host_rnw, host_addr, host_wdata}),
      .q     (sync_q)
   );
   assign {avalid_s, rnw_s, addr_s, wdata_s} = sync_q;

   logic             sel_w;
   logic [REG_W-1:0] reg_w;

   hdmb_id_match #(.HOST_AW(HOST_AW), .REG_W(REG_W), .CARD_ID(CARD_ID)) u_match (
      .avalid  (avalid_s),
      .addr    (addr_s),
      .sel     (sel_w),
      .reg_idx (reg_w)
   );

   // local port decode
   logic rd_mbox, rd_din, wr_dout, wr_hirq;
   assign rd_mbox = dsp_rd && (dsp_addr == A_ADDR);
   assign rd_din  = dsp_rd && (dsp_addr == A_DIN);
   assign wr_dout = dsp_wr && (dsp_addr == A_DOUT);
   assign wr_hirq = dsp_wr && (dsp_addr == A_HIRQ);

   hdmb_state_t       st_w;
   logic [REG_W:0]    lat_w;
   logic [DATA_W-1:0] din_w;

   hdmb_xfer_ctl #(.REG_W(REG_W), .DATA_W(DATA_W)) u_xfer (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_w),
      .rnw     (rnw_s),
      .reg_idx (reg_w),
      .wdata   (wdata_s),
      .rd_mbox (rd_mbox),
      .rd_din  (rd_din),
      .st      (st_w),
      .lat     (lat_w),
      .din     (din_w)
   );

   // outbound register
   logic [DATA_W-1:0] dout_q;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       dout_q <= '0;
      else if (wr_dout) dout_q <= dsp_wdata;

   // host interrupt request
   logic hreq_q;
   hdmb_req_ff u_hreq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (wr_hirq && dsp_wdata[0]),
      .clr_req (wr_hirq && dsp_wdata[1]),
      .q       (hreq_q)
   );

   always_comb begin
      dsp_rdata = '0;
      if (dsp_addr == A_ADDR)     dsp_rdata = DATA_W'(lat_w);
      else if (dsp_addr == A_DIN) dsp_rdata = din_w;
   end

   assign dsp_irq     = (st_w == ST_PEND);
   assign host_dack_n = (st_w != ST_ACK);
   assign host_rdata  = dout_q;
   assign host_irq_n  = !hreq_q;
endmodule

// File: rtl/hdmb_bridge_chk.sv
module hdmb_bridge_chk
   import hdmb_pkg::*;
#(
   parameter int REG_W  = 4,
   parameter int DATA_W = 16,
   parameter int LOC_AW = 3,
   parameter int P_ADDR = 0,
   parameter int P_DIN  = 1,
   parameter int P_DOUT = 2,
   parameter int P_HIRQ = 3
) (
   input logic              clk,
   input logic              rst_n,
   input hdmb_state_t       st,
   input logic              sel,
   input logic [REG_W:0]    lat,
   input logic [LOC_AW-1:0] dsp_addr,
   input logic              dsp_rd,
   input logic              dsp_wr,
   input logic [DATA_W-1:0] dsp_wdata,
   input logic              dsp_irq,
   input logic              host_dack_n,
   input logic              host_irq_n,
   input logic [DATA_W-1:0] host_rdata
);
   localparam logic [LOC_AW-1:0] A_ADDR = LOC_AW'(P_ADDR);
   localparam logic [LOC_AW-1:0] A_DIN  = LOC_AW'(P_DIN);
   localparam logic [LOC_AW-1:0] A_DOUT = LOC_AW'(P_DOUT);
   localparam logic [LOC_AW-1:0] A_HIRQ = LOC_AW'(P_HIRQ);

   p_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && sel) |=> dsp_irq);

   p_mbox_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_irq && dsp_rd && dsp_addr == A_ADDR) |=> !dsp_irq);

   p_dout_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_wr && dsp_addr == A_DOUT) |=> host_rdata == $past(dsp_wdata));

   p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_XFER && dsp_rd && dsp_addr == A_DIN) |=> !host_dack_n);

   p_no_early_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!host_dack_n && dsp_irq));

   p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_irq && $past(dsp_irq)) |-> $stable(lat));

   p_hirq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_wr && dsp_addr == A_HIRQ && dsp_wdata[0] && !dsp_wdata[1]) |=> !host_irq_n);

   p_hirq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_wr && dsp_addr == A_HIRQ && dsp_wdata[1]) |=> host_irq_n);
endmodule

bind hdmb_bridge hdmb_bridge_chk #(
   .REG_W(REG_W), .DATA_W(DATA_W), .LOC_AW(LOC_AW),
   .P_ADDR(P_ADDR), .P_DIN(P_DIN), .P_DOUT(P_DOUT), .P_HIRQ(P_HIRQ)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .st          (st_w),
   .sel         (sel_w),
   .lat         (lat_w),
   .dsp_addr    (dsp_addr),
   .dsp_rd      (dsp_rd),
   .dsp_wr      (dsp_wr),
   .dsp_wdata   (dsp_wdata),
   .dsp_irq     (dsp_irq),
   .host_dack_n (host_dack_n),
   .host_irq_n  (host_irq_n),
   .host_rdata  (host_rdata)
);

// File: tb/hdmb_bridge_test.sv
module hdmb_bridge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_avalid = 1'b0;
   logic        host_rnw = 1'b0;
   logic [15:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        host_dack_n, host_irq_n;
   logic [2:0]  dsp_addr = '0;
   logic        dsp_rd = 1'b0;
   logic        dsp_wr = 1'b0;
   logic [15:0] dsp_wdata = '0;
   logic [15:0] dsp_rdata;
   logic        dsp_irq;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   localparam logic [2:0] PA = 3'd0, PI = 3'd1, PO = 3'd2, PH = 3'd3;

   always #10 clk = ~clk;

   hdmb_bridge uut (
      .clk(clk), .rst_n(rst_n),
      .host_avalid(host_avalid), .host_rnw(host_rnw), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_dack_n(host_dack_n), .host_irq_n(host_irq_n),
      .dsp_addr(dsp_addr), .dsp_rd(dsp_rd), .dsp_wr(dsp_wr),
      .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata), .dsp_irq(dsp_irq)
   );

   localparam int NV = 4;
   localparam logic [15:0] V_ADDR [NV] = '{16'hA5C3, 16'hA5CF, 16'hA5C0, 16'hA5C8};
   localparam logic        V_RNW  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};
   localparam logic [15:0] V_DATA [NV] = '{16'h1234, 16'hBEEF, 16'hFFFF, 16'h0001};

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic dsp_read(input logic [2:0] a, output logic [15:0] v);
      @(negedge clk);
      dsp_addr = a; dsp_rd = 1'b1;
      #1 v = dsp_rdata;
      @(negedge clk);
      dsp_rd = 1'b0;
      #1;
   endtask

   task automatic dsp_write(input logic [2:0] a, input logic [15:0] v);
      @(negedge clk);
      dsp_addr = a; dsp_wr = 1'b1; dsp_wdata = v;
      @(negedge clk);
      dsp_wr = 1'b0;
      #1;
   endtask

   task automatic host_start(input logic [15:0] a, input logic rnw, input logic [15:0] wd);
      @(negedge clk);
      host_addr = a; host_rnw = rnw; host_wdata = wd; host_avalid = 1'b1;
   endtask

   initial begin : main
      logic [15:0] v;
      tick(3);
      // R1 reset state
      chk(host_dack_n === 1'b1, "R1", "dack_n in reset", 32'(host_dack_n), 1);
      chk(host_irq_n === 1'b1, "R1", "irq_n in reset", 32'(host_irq_n), 1);
      chk(dsp_irq === 1'b0, "R1", "dsp_irq in reset", 32'(dsp_irq), 0);
      rst_n = 1'b1;
      tick(2);

      // vector table: full host write / read transactions
      for (int i = 0; i < NV; i++) begin
         host_start(V_ADDR[i], V_RNW[i], V_RNW[i] ? 16'h0 : V_DATA[i]);
         tick(4);
         chk(dsp_irq === 1'b1, "R2", "irq on card match", 32'(dsp_irq), 1);
         dsp_read(PA, v);
         chk(v === {11'h0, V_RNW[i], V_ADDR[i][3:0]}, "R3", "mailbox word", 32'(v),
             32'({11'h0, V_RNW[i], V_ADDR[i][3:0]}));
         chk(dsp_irq === 1'b0, "R3", "irq cleared by mailbox read", 32'(dsp_irq), 0);
         if (V_RNW[i]) begin
            dsp_write(PO, V_DATA[i]);
            chk(host_rdata === V_DATA[i], "R5", "host read data", 32'(host_rdata), 32'(V_DATA[i]));
         end
         dsp_read(PI, v);
         if (!V_RNW[i])
            chk(v === V_DATA[i], "R4", "inbound data", 32'(v), 32'(V_DATA[i]));
         chk(host_dack_n === 1'b0, "R6", "ack after inbound read", 32'(host_dack_n), 0);
         tick(3);
         chk(host_dack_n === 1'b0, "R7", "ack held while address valid", 32'(host_dack_n), 0);
         @(negedge clk) host_avalid = 1'b0;
         tick(4);
         chk(host_dack_n === 1'b1, "R7", "ack released on address drop", 32'(host_dack_n), 1);
      end

      // R11 foreign address and invalid strobe
      host_start(16'h1234, 1'b0, 16'h5555);
      tick(6);
      chk(dsp_irq === 1'b0, "R11", "no irq for foreign address", 32'(dsp_irq), 0);
      dsp_read(PI, v);
      chk(host_dack_n === 1'b1, "R11", "no ack for foreign address", 32'(host_dack_n), 1);
      @(negedge clk) begin host_avalid = 1'b0; host_addr = 16'hA5C1; end
      tick(6);
      chk(dsp_irq === 1'b0, "R11", "no irq with avalid low", 32'(dsp_irq), 0);

      // R6 inbound read before the mailbox read gives no ack
      host_start(16'hA5C2, 1'b0, 16'hCAFE);
      tick(4);
      dsp_read(PI, v);
      chk(host_dack_n === 1'b1, "R6", "no ack while irq pending", 32'(host_dack_n), 1);
      chk(dsp_irq === 1'b1, "R6", "irq still pending", 32'(dsp_irq), 1);

      // R8 second address while pending: stall, then its own access
      @(negedge clk) host_addr = 16'hA5C7;
      tick(5);
      chk(host_dack_n === 1'b1, "R8", "no ack for stalled access", 32'(host_dack_n), 1);
      dsp_read(PA, v);
      chk(v === 16'h0002, "R8", "first address kept", 32'(v), 32'h2);
      dsp_read(PI, v);
      tick(5);
      chk(dsp_irq === 1'b1, "R8", "new access raised", 32'(dsp_irq), 1);
      dsp_read(PA, v);
      chk(v === 16'h0007, "R8", "second address latched", 32'(v), 32'h7);
      dsp_read(PI, v);
      chk(host_dack_n === 1'b0, "R6", "ack for second access", 32'(host_dack_n), 0);
      @(negedge clk) host_avalid = 1'b0;
      tick(4);
      chk(host_dack_n === 1'b1, "R7", "second ack released", 32'(host_dack_n), 1);

      // R9 host request set, clear, priority
      dsp_write(PH, 16'h0001);
      chk(host_irq_n === 1'b0, "R9", "host irq set", 32'(host_irq_n), 0);
      dsp_write(PH, 16'h0002);
      chk(host_irq_n === 1'b1, "R9", "host irq clear", 32'(host_irq_n), 1);
      dsp_write(PH, 16'h0003);
      chk(host_irq_n === 1'b1, "R9", "clear wins from idle", 32'(host_irq_n), 1);
      dsp_write(PH, 16'h0001);
      dsp_write(PH, 16'h0003);
      chk(host_irq_n === 1'b1, "R9", "clear wins from set", 32'(host_irq_n), 1);

      // R10 system reset clears a pending host request
      dsp_write(PH, 16'h0001);
      @(negedge clk) rst_n = 1'b0;
      #1;
      chk(host_irq_n === 1'b1, "R10", "reset clears host irq", 32'(host_irq_n), 1);
      tick(2);
      rst_n = 1'b1;
      tick(2);
      chk(host_irq_n === 1'b1, "R10", "stays clear after reset", 32'(host_irq_n), 1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule